// File: doc/BRIEF.md
# Integer ALU with Selective Status Flags

This block is the integer execution stage of a single-issue 32-bit two-operand core. The destination register value arrives on `opnd_a` and doubles as the first operand. The second operand arrives on `opnd_b` as either a register value or an immediate the decoder has already sign-extended. Shift operations take their count from a separate 5-bit input instead. The unit computes the result and a write request, and it keeps a four-bit status register. Each operation changes only the status bits that belong to it.

Results and status are registered. An operation presented with `in_valid` high on a rising edge shows its result, write request and new status right after that edge. The decoder and the register file sit outside. When `wr_r0_q` is high, the write goes to register 0 rather than the destination register; the leading-count operations use it. Compare and test change status only.

Status bit order on `flags_q` is {C, Z, S, V}: C is bit 3, Z is bit 2, S is bit 1 and V is bit 0. Z means the result is zero and S is its most significant bit. For subtraction, C means a borrow occurred.

Top module: `int_alu_flags`

## Requirements
- R1: A synchronous active-high reset clears `flags_q`, `wr_en_q`, `wr_r0_q` and `result_q` to zero at the next rising edge.
- R2: ADD (opcode 0) produces a+b. ADC (opcode 1) produces a+b+C. Both set C to the carry out, V to signed overflow, and Z and S from the result.
- R3: SUB (opcode 2) produces a-b. SBC (opcode 3) produces a-b-C. Both set C when an unsigned borrow occurs, V on signed overflow, and Z and S from the result.
- R4: CMP (opcode 4) sets all four flags as SUB would for a-b, and TST (opcode 5) sets Z and S from a AND b. Neither raises `wr_en_q`.
- R5: AND (6), OR (7), XOR (8) and NOT (9, result ~a, b ignored) write their result and update Z and S. Like TST, they leave C and V unchanged.
- R6: ASR (10) shifts right and fills with the sign bit, and LSR (11) shifts right and fills with zeros. C takes the last bit shifted out, Z and S follow the result, and V is unchanged.
- R7: A shift with `shamt` of zero returns a unchanged, updates Z and S, and leaves C and V unchanged.
- R8: ASL (12) shifts left and fills with zeros, and SSL (13) shifts left and fills with ones. C takes the last bit shifted out of bit 31, and V is unchanged.
- R9: EXTB (14) and EXTS (15) sign-extend a[7:0] and a[15:0]. CVB (16) and CVS (17) zero-extend them. All four write in place, update Z and S, and leave C and V unchanged.
- R10: CLZ (18) and CLO (19) count the leading zeros or leading ones of a, with 32 for a uniform word. They raise both `wr_en_q` and `wr_r0_q`, and change only Z (set when the count is zero).
- R11: A cycle with `in_valid` low, or with an opcode above 19, leaves `flags_q` unchanged and `wr_en_q` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is present this cycle |
| opcode | input | 5 | Operation code |
| opnd_a | input | 32 | Destination operand (first operand) |
| opnd_b | input | 32 | Source register or sign-extended immediate |
| shamt | input | 5 | Shift count |
| result_q | output | 32 | Registered result |
| wr_en_q | output | 1 | Registered register-write request |
| wr_r0_q | output | 1 | Write targets register 0 instead of the destination |
| flags_q | output | 4 | Status {C, Z, S, V} |

## Verification
The hardest cases to reach are those where a flag must survive an operation that does not own it. That can only be seen when the flag already holds a 1. The stimulus table is ordered so that an overflowing add sets V, and a borrowing compare or a one-bit right shift sets C. The logic, shift, extend and count operations that follow must then leave those ones in place. In the same way, ADC and SBC run with a carry of 1 on boundary operands, and a zero-count shift runs directly after a shift that set C.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int DW = 32;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_CMP  = 5'd4,  OP_TST  = 5'd5,  OP_AND  = 5'd6,  OP_OR   = 5'd7,
    OP_XOR  = 5'd8,  OP_NOT  = 5'd9,  OP_ASR  = 5'd10, OP_LSR  = 5'd11,
    OP_ASL  = 5'd12, OP_SSL  = 5'd13, OP_EXTB = 5'd14, OP_EXTS = 5'd15,
    OP_CVB  = 5'd16, OP_CVS  = 5'd17, OP_CLZ  = 5'd18, OP_CLO  = 5'd19
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic v;
  } alu_flags_t;

  typedef enum logic [1:0] {SH_ASR, SH_LSR, SH_ASL, SH_SSL} shift_kind_e;

  typedef enum logic [2:0] {
    BO_AND, BO_OR, BO_XOR, BO_NOT, BO_EXTB, BO_EXTS, BO_CVB, BO_CVS
  } bitop_e;
endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         use_c,
  input  logic         c_in,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         v_out
);
  logic [W-1:0] b_eff;
  logic         cy_in;
  logic [W:0]   wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    // subtract: a + ~b + 1 - borrow_in
    cy_in = sub ? ~(use_c & c_in) : (use_c & c_in);
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cy_in};
    sum   = wide[W-1:0];
    c_out = sub ? ~wide[W] : wide[W];
    v_out = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
  end
endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift
  import int_alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [SW-1:0] n,
  input  shift_kind_e   kind,
  output logic [W-1:0]  res,
  output logic          c_out,
  output logic          c_upd
);
  logic [SW:0]   left_idx;
  logic [SW-1:0] right_idx;
  logic [W-1:0]  ones_mask;

  always_comb begin
    left_idx  = (SW+1)'(W) - {1'b0, n};
    right_idx = n - 1'b1;
    ones_mask = ~({W{1'b1}} << n);
    c_upd     = (n != '0);
    unique case (kind)
      SH_ASR: begin
        res   = $unsigned($signed(a) >>> n);
        c_out = a[right_idx];
      end
      SH_LSR: begin
        res   = a >> n;
        c_out = a[right_idx];
      end
      SH_ASL: begin
        res   = a << n;
        c_out = a[left_idx[SW-1:0]];
      end
      default: begin
        res   = (a << n) | ones_mask;
        c_out = a[left_idx[SW-1:0]];
      end
    endcase
  end
endmodule

// File: rtl/int_alu_bitops.sv
module int_alu_bitops
  import int_alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  bitop_e        sel,
  input  logic          count_ones,
  output logic [W-1:0]  res,
  output logic [CW-1:0] lead_cnt
);
  logic [W-1:0] scan;
  logic         hit;

  always_comb begin
    unique case (sel)
      BO_AND:  res = a & b;
      BO_OR:   res = a | b;
      BO_XOR:  res = a ^ b;
      BO_NOT:  res = ~a;
      BO_EXTB: res = {{(W-8){a[7]}}, a[7:0]};
      BO_EXTS: res = {{(W-16){a[15]}}, a[15:0]};
      BO_CVB:  res = {{(W-8){1'b0}}, a[7:0]};
      default: res = {{(W-16){1'b0}}, a[15:0]};
    endcase
  end

  // leading count: scan from the top until the first differing bit
  always_comb begin
    scan     = count_ones ? ~a : a;
    lead_cnt = CW'(W);
    hit      = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit && scan[i]) begin
        lead_cnt = CW'(W - 1 - i);
        hit      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
  import int_alu_pkg::*;
#(
  parameter int W  = DW,
  parameter int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [4:0]    opcode,
  input  logic [W-1:0]  opnd_a,
  input  logic [W-1:0]  opnd_b,
  input  logic [SW-1:0] shamt,
  output logic [W-1:0]  result_q,
  output logic          wr_en_q,
  output logic          wr_r0_q,
  output logic [3:0]    flags_q
);
  localparam int CW = SW + 1;

  alu_flags_t   st_q, st_d, mask;
  alu_op_e      op;
  logic         arith_sub, arith_usec;
  logic [W-1:0] arith_sum;
  logic         arith_c, arith_v;
  shift_kind_e  sh_kind;
  logic [W-1:0] sh_res;
  logic         sh_c, sh_cupd;
  bitop_e       bo_sel;
  logic [W-1:0] bo_res;
  logic [CW-1:0] cnt;
  logic [W-1:0] res_d;
  logic         wen_d, r0_d;
  alu_flags_t   calc;

  assign op = alu_op_e'(opcode);

  int_alu_addsub #(.W(W)) u_arith (
    .a(opnd_a), .b(opnd_b), .sub(arith_sub), .use_c(arith_usec),
    .c_in(st_q.c), .sum(arith_sum), .c_out(arith_c), .v_out(arith_v)
  );

  int_alu_shift #(.W(W), .SW(SW)) u_shift (
    .a(opnd_a), .n(shamt), .kind(sh_kind),
    .res(sh_res), .c_out(sh_c), .c_upd(sh_cupd)
  );

  int_alu_bitops #(.W(W), .CW(CW)) u_bits (
    .a(opnd_a), .b(opnd_b), .sel(bo_sel), .count_ones(op == OP_CLO),
    .res(bo_res), .lead_cnt(cnt)
  );

  // operation decode: sub-unit controls, result source, flag mask
  always_comb begin
    arith_sub  = 1'b0;
    arith_usec = 1'b0;
    sh_kind    = SH_ASR;
    bo_sel     = BO_AND;
    res_d      = arith_sum;
    calc       = '{c: arith_c, z: (arith_sum == '0), s: arith_sum[W-1], v: arith_v};
    mask       = '0;
    wen_d      = 1'b0;
    r0_d       = 1'b0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
        arith_sub  = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);
        arith_usec = (op == OP_ADC) || (op == OP_SBC);
        mask       = '{c: 1'b1, z: 1'b1, s: 1'b1, v: 1'b1};
        wen_d      = (op != OP_CMP);
      end
      OP_TST, OP_AND, OP_OR, OP_XOR, OP_NOT,
      OP_EXTB, OP_EXTS, OP_CVB, OP_CVS: begin
        unique case (op)
          OP_OR:   bo_sel = BO_OR;
          OP_XOR:  bo_sel = BO_XOR;
          OP_NOT:  bo_sel = BO_NOT;
          OP_EXTB: bo_sel = BO_EXTB;
          OP_EXTS: bo_sel = BO_EXTS;
          OP_CVB:  bo_sel = BO_CVB;
          OP_CVS:  bo_sel = BO_CVS;
          default: bo_sel = BO_AND;
        endcase
        res_d = bo_res;
        calc  = '{c: 1'b0, z: (bo_res == '0), s: bo_res[W-1], v: 1'b0};
        mask  = '{c: 1'b0, z: 1'b1, s: 1'b1, v: 1'b0};
        wen_d = (op != OP_TST);
      end
      OP_ASR, OP_LSR, OP_ASL, OP_SSL: begin
        unique case (op)
          OP_LSR:  sh_kind = SH_LSR;
          OP_ASL:  sh_kind = SH_ASL;
          OP_SSL:  sh_kind = SH_SSL;
          default: sh_kind = SH_ASR;
        endcase
        res_d = sh_res;
        calc  = '{c: sh_c, z: (sh_res == '0), s: sh_res[W-1], v: 1'b0};
        mask  = '{c: sh_cupd, z: 1'b1, s: 1'b1, v: 1'b0};
        wen_d = 1'b1;
      end
      OP_CLZ, OP_CLO: begin
        res_d = {{(W-CW){1'b0}}, cnt};
        calc  = '{c: 1'b0, z: (cnt == '0), s: 1'b0, v: 1'b0};
        mask  = '{c: 1'b0, z: 1'b1, s: 1'b0, v: 1'b0};
        wen_d = 1'b1;
        r0_d  = 1'b1;
      end
      default: ;
    endcase
    st_d = (calc & mask) | (st_q & ~mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= '0;
      result_q <= '0;
      wr_en_q  <= 1'b0;
      wr_r0_q  <= 1'b0;
    end else begin
      wr_en_q <= in_valid & wen_d;
      wr_r0_q <= in_valid & r0_d;
      if (in_valid) begin
        st_q     <= st_d;
        result_q <= res_d;
      end
    end
  end

  assign flags_q = st_q;
endmodule

// File: rtl/int_alu_flags_chk.sv
module int_alu_flags_chk
  import int_alu_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [4:0] opcode,
  input logic [4:0] shamt,
  input logic       wr_en_q,
  input logic       wr_r0_q,
  input logic [3:0] flags_q
);
  logic is_logic, is_shift, is_count, is_noreg;
  assign is_logic = in_valid && (opcode >= 5'd5) && (opcode <= 5'd9);
  assign is_shift = in_valid && (opcode >= 5'd10) && (opcode <= 5'd13);
  assign is_count = in_valid && (opcode == 5'd18 || opcode == 5'd19);
  assign is_noreg = in_valid && (opcode == 5'd4 || opcode == 5'd5);

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (flags_q == 4'b0000) && !wr_en_q && !wr_r0_q);

  p_cmp_tst_nowrite_r4: assert property (@(posedge clk) disable iff (rst)
    is_noreg |=> !wr_en_q);

  p_logic_keeps_cv_r5: assert property (@(posedge clk) disable iff (rst)
    is_logic |=> $stable(flags_q[3]) && $stable(flags_q[0]));

  p_shift_keeps_v_r6: assert property (@(posedge clk) disable iff (rst)
    is_shift |=> $stable(flags_q[0]));

  p_shift_zero_keeps_c_r7: assert property (@(posedge clk) disable iff (rst)
    (is_shift && shamt == 5'd0) |=> $stable(flags_q[3]));

  p_count_z_only_r10: assert property (@(posedge clk) disable iff (rst)
    is_count |=> wr_en_q && wr_r0_q && $stable(flags_q[3]) &&
                 $stable(flags_q[1]) && $stable(flags_q[0]));

  p_idle_holds_r11: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || opcode > 5'd19) |=> $stable(flags_q) && !wr_en_q && !wr_r0_q);
endmodule

bind int_alu_flags int_alu_flags_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
  .shamt(shamt), .wr_en_q(wr_en_q), .wr_r0_q(wr_r0_q), .flags_q(flags_q)
);

// File: tb/tb_int_alu_flags.sv
module tb_int_alu_flags;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [4:0]  opcode;
  logic [31:0] opnd_a, opnd_b;
  logic [4:0]  shamt;
  logic [31:0] result_q;
  logic        wr_en_q, wr_r0_q;
  logic [3:0]  flags_q;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  int_alu_flags dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .shamt(shamt),
    .result_q(result_q), .wr_en_q(wr_en_q), .wr_r0_q(wr_r0_q), .flags_q(flags_q)
  );

  // {req, op, a, b, shamt, result, wen, r0, flags{C,Z,S,V}}
  localparam int NV = 32;
  localparam logic [115:0] VEC [NV] = '{
    {4'd2,  5'd0,  32'h7FFFFFFF, 32'h00000001, 5'd0, 32'h80000000, 1'b1, 1'b0, 4'b0011}, // R2
    {4'd2,  5'd0,  32'hFFFFFFFF, 32'h00000001, 5'd0, 32'h00000000, 1'b1, 1'b0, 4'b1100}, // R2
    {4'd2,  5'd1,  32'h00000005, 32'h00000006, 5'd0, 32'h0000000C, 1'b1, 1'b0, 4'b0000}, // R2 C=1 in
    {4'd3,  5'd2,  32'h00000003, 32'h00000005, 5'd0, 32'hFFFFFFFE, 1'b1, 1'b0, 4'b1010}, // R3
    {4'd3,  5'd3,  32'h0000000A, 32'h00000003, 5'd0, 32'h00000006, 1'b1, 1'b0, 4'b0000}, // R3 C=1 in
    {4'd3,  5'd2,  32'h80000000, 32'h00000001, 5'd0, 32'h7FFFFFFF, 1'b1, 1'b0, 4'b0001}, // R3
    {4'd4,  5'd4,  32'h00000007, 32'h00000007, 5'd0, 32'h00000000, 1'b0, 1'b0, 4'b0100}, // R4
    {4'd4,  5'd4,  32'h00000001, 32'h00000002, 5'd0, 32'h00000000, 1'b0, 1'b0, 4'b1010}, // R4
    {4'd5,  5'd6,  32'hF0F0F0F0, 32'h0F0F0F0F, 5'd0, 32'h00000000, 1'b1, 1'b0, 4'b1100}, // R5
    {4'd5,  5'd7,  32'h80000000, 32'h00000001, 5'd0, 32'h80000001, 1'b1, 1'b0, 4'b1010}, // R5
    {4'd5,  5'd8,  32'hFFFF0000, 32'hFFFFFFFF, 5'd0, 32'h0000FFFF, 1'b1, 1'b0, 4'b1000}, // R5
    {4'd5,  5'd9,  32'hFFFFFFFF, 32'h00001234, 5'd0, 32'h00000000, 1'b1, 1'b0, 4'b1100}, // R5
    {4'd4,  5'd5,  32'h80000000, 32'hFFFFFFFF, 5'd0, 32'h00000000, 1'b0, 1'b0, 4'b1010}, // R4
    {4'd2,  5'd0,  32'h80000000, 32'h80000000, 5'd0, 32'h00000000, 1'b1, 1'b0, 4'b1101}, // R2
    {4'd5,  5'd8,  32'h00000001, 32'h00000003, 5'd0, 32'h00000002, 1'b1, 1'b0, 4'b1001}, // R5
    {4'd6,  5'd10, 32'h80000010, 32'h00000000, 5'd4, 32'hF8000001, 1'b1, 1'b0, 4'b0011}, // R6
    {4'd6,  5'd11, 32'h80000018, 32'h00000000, 5'd4, 32'h08000001, 1'b1, 1'b0, 4'b1001}, // R6
    {4'd8,  5'd12, 32'h20000001, 32'h00000000, 5'd2, 32'h80000004, 1'b1, 1'b0, 4'b0011}, // R8
    {4'd8,  5'd13, 32'h00000001, 32'h00000000, 5'd3, 32'h0000000F, 1'b1, 1'b0, 4'b0001}, // R8
    {4'd6,  5'd11, 32'h00000001, 32'h00000000, 5'd1, 32'h00000000, 1'b1, 1'b0, 4'b1101}, // R6
    {4'd7,  5'd10, 32'h80000000, 32'h00000000, 5'd0, 32'h80000000, 1'b1, 1'b0, 4'b1011}, // R7
    {4'd9,  5'd14, 32'h12345680, 32'h00000000, 5'd0, 32'hFFFFFF80, 1'b1, 1'b0, 4'b1011}, // R9
    {4'd9,  5'd15, 32'hABCD7FFF, 32'h00000000, 5'd0, 32'h00007FFF, 1'b1, 1'b0, 4'b1001}, // R9
    {4'd9,  5'd16, 32'hFFFFFF00, 32'h00000000, 5'd0, 32'h00000000, 1'b1, 1'b0, 4'b1101}, // R9
    {4'd9,  5'd17, 32'h80018001, 32'h00000000, 5'd0, 32'h00008001, 1'b1, 1'b0, 4'b1001}, // R9
    {4'd10, 5'd18, 32'h00010000, 32'h00000000, 5'd0, 32'h0000000F, 1'b1, 1'b1, 4'b1001}, // R10
    {4'd10, 5'd18, 32'h00000000, 32'h00000000, 5'd0, 32'h00000020, 1'b1, 1'b1, 4'b1001}, // R10
    {4'd10, 5'd19, 32'h7FFFFFFF, 32'h00000000, 5'd0, 32'h00000000, 1'b1, 1'b1, 4'b1101}, // R10
    {4'd10, 5'd19, 32'hFFFFFFFF, 32'h00000000, 5'd0, 32'h00000020, 1'b1, 1'b1, 4'b1001}, // R10
    {4'd3,  5'd3,  32'h00000000, 32'h00000000, 5'd0, 32'hFFFFFFFF, 1'b1, 1'b0, 4'b1010}, // R3
    {4'd2,  5'd1,  32'hFFFFFFFF, 32'h00000000, 5'd0, 32'h00000000, 1'b1, 1'b0, 4'b1100}, // R2
    {4'd11, 5'd31, 32'h7FFFFFFF, 32'h00000001, 5'd0, 32'h00000000, 1'b0, 1'b0, 4'b1100}  // R11
  };

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; opcode = '0;
    opnd_a = '0; opnd_b = '0; shamt = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1", "flags", {28'd0, flags_q}, 32'd0);
    check("R1", "wen", {31'd0, wr_en_q}, 32'd0);
    check("R1", "r0", {31'd0, wr_r0_q}, 32'd0);
    check("R1", "result", result_q, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag      = $sformatf("R%0d", VEC[i][115:112]);
      in_valid = 1'b1;
      opcode   = VEC[i][111:107];
      opnd_a   = VEC[i][106:75];
      opnd_b   = VEC[i][74:43];
      shamt    = VEC[i][42:38];
      @(negedge clk);
      check(tag, "flags", {28'd0, flags_q}, {28'd0, VEC[i][3:0]});
      check(tag, "wen", {31'd0, wr_en_q}, {31'd0, VEC[i][5]});
      check(tag, "r0", {31'd0, wr_r0_q}, {31'd0, VEC[i][4]});
      if (VEC[i][5]) check(tag, "result", result_q, VEC[i][37:6]);
    end

    // R11: valid low with an ADD that would change every flag (flags now 1100)
    in_valid = 1'b0; opcode = 5'd0; opnd_a = 32'h7FFFFFFF; opnd_b = 32'h1;
    @(negedge clk);
    check("R11", "idle flags", {28'd0, flags_q}, 32'hC);
    check("R11", "idle wen", {31'd0, wr_en_q}, 32'd0);

    // R7: zero-count left shift keeps C=1 (flags 1100), V held 0
    in_valid = 1'b1; opcode = 5'd12; opnd_a = 32'h00000003; shamt = 5'd0;
    @(negedge clk);
    check("R7", "flags", {28'd0, flags_q}, 32'h8);
    check("R7", "result", result_q, 32'h00000003);

    // R8: left shift by 31 moves bit 1 out into C
    opcode = 5'd12; opnd_a = 32'h00000002; shamt = 5'd31;
    @(negedge clk);
    check("R8", "flags", {28'd0, flags_q}, 32'hC);
    check("R8", "result", result_q, 32'h00000000);

    // R1: reset in the middle of a run
    rst = 1'b1; opcode = 5'd0; opnd_a = 32'h7FFFFFFF; opnd_b = 32'h1;
    @(negedge clk);
    check("R1", "flags mid-run", {28'd0, flags_q}, 32'd0);
    check("R1", "wen mid-run", {31'd0, wr_en_q}, 32'd0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule